// File: doc/BRIEF.md
# Delta-Decoding Line Expander

This block sits between an input line FIFO and a consumer of 512-bit lines, each holding sixteen 32-bit elements. Some lines in the input stream are packed pairs. A packed line carries two halves, and each half describes one original line as a 32-bit base element followed by fifteen 13-bit differences between neighbouring elements. The expander tells packed lines from plain ones by a marker in the top bits. It rebuilds each half into a full line and forwards plain lines unchanged. The output stream is the original line stream, in its original order.

The first element of a half is its base. Each later element is the previous element plus its difference. This running sum is split over a chain of registered adder stages, so no single clock period carries the whole chain. The input side reads the head of a show-ahead FIFO and returns a one-cycle dequeue strobe. A packed line stays at the FIFO head while both of its halves enter the pipeline, and it is dequeued together with its second half. The output side is a valid/ready interface. Backpressure there stalls the whole pipeline.

Top module: `delta_line_expander`

## Requirements
- R1: A line is packed when its bits [511:479] equal 32 zero bits followed by a one (bit 479 = 1, bits [511:480] = 0). Any other value in that field marks the line as plain, including values that differ from the marker in a single bit.
- R2: A plain line appears on `out_line` with every bit unchanged. `in_deq` is high in the same cycle that the line enters the pipeline, and whenever `in_valid` is high, the line is plain and the pipeline can advance (`out_ready` high or `out_valid` low).
- R3: A packed line holds half A in bits [478:252] and half B in bits [251:25]. Bits [24:0] are ignored. Within a 227-bit half, the base is in bits [31:0] and difference i (i = 1..15) is in bits [32+13*(i-1) +: 13]. Output element i sits at `out_line[32*i +: 32]` and equals the base plus differences 1..i. The differences are zero-extended and the sum wraps modulo 2^32.
- R4: A packed line yields two output lines, half A first and then half B. It is dequeued exactly once, on the cycle its half B enters the pipeline, and never in the cycle right after it was dequeued.
- R5: Output lines leave in input order, with no loss or duplication, for any mix of plain and packed lines.
- R6: While `out_valid` is high and `out_ready` is low, the next cycle still has `out_valid` high and the same `out_line`.
- R7: With `out_ready` held high and the pipeline empty, a line accepted at a clock edge first shows on `out_valid`/`out_line` after the edge that lies ceil(15/GROUP) - 1 edges later. With the default GROUP = 4, this is 4 cycles after the cycle of acceptance.
- R8: While `rst` is high, `in_deq` stays low. After reset, `out_valid` is low and the next line taken is treated from its first half.
- R9: `in_deq` is only high while `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input FIFO head holds a line |
| in_line | input | 512 | Input FIFO head line (show-ahead) |
| in_deq | output | 1 | Pops the FIFO head at the next edge |
| out_valid | output | 1 | `out_line` carries a decoded line |
| out_ready | input | 1 | Consumer takes the line this cycle |
| out_line | output | 512 | Decoded or forwarded line |

## Verification
The bound checker watches four things on every cycle: the dequeue strobe only appears with a valid head (R9), a plain head is always dequeued when the pipeline can move (R2), a held output stays frozen under backpressure (R6), and a packed line is never dequeued without its first half having gone in during an earlier cycle (R4). The arithmetic of the running sum, the half order, modular wrap, end-to-end ordering across mixed streams and the pipeline latency can only be shown by the bench. It encodes random and sorted line streams with its own packer and compares every output line against the original stream.

// File: rtl/dx_pkg.sv
package dx_pkg;
  localparam int LINE_W  = 512;
  localparam int ELEM_W  = 32;
  localparam int N_ELEM  = LINE_W / ELEM_W;
  localparam int DELTA_W = 13;
  localparam int FLAG_W  = 33;
  localparam int N_DELTA = N_ELEM - 1;
  localparam int HALF_W  = ELEM_W + N_DELTA * DELTA_W;
  localparam int HALF_A_LSB = LINE_W - FLAG_W - HALF_W;
  localparam int HALF_B_LSB = HALF_A_LSB - HALF_W;

  typedef logic [LINE_W-1:0] line_t;
  typedef logic [HALF_W-1:0] half_t;

  // Marker: all-zero element 15 followed by a single set bit
  function automatic logic is_packed(line_t l);
    return l[LINE_W-1 -: FLAG_W] == {{(FLAG_W-1){1'b0}}, 1'b1};
  endfunction

  // Spread one half into lanes: lane 0 = base, lane i = zero-extended delta i
  function automatic line_t half_to_lanes(half_t h);
    line_t r;
    r = '0;
    r[0 +: ELEM_W] = h[0 +: ELEM_W];
    for (int i = 1; i <= N_DELTA; i++)
      r[ELEM_W*i +: ELEM_W] = {{(ELEM_W-DELTA_W){1'b0}}, h[ELEM_W+DELTA_W*(i-1) +: DELTA_W]};
    return r;
  endfunction
endpackage

// File: rtl/dx_front.sv
module dx_front
  import dx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  input  line_t in_line,
  input  logic  adv,
  output logic  in_deq,
  output logic  inj_valid,
  output logic  inj_plain,
  output line_t inj_lanes
);
  logic second_q;   // next half of a packed head is half B
  logic packed_w;
  logic take;

  assign packed_w  = is_packed(in_line);
  assign take      = adv && in_valid && !rst;
  assign in_deq    = take && (!packed_w || second_q);
  assign inj_valid = take;
  assign inj_plain = !packed_w;

  always_comb begin
    if (!packed_w)
      inj_lanes = in_line;
    else if (second_q)
      inj_lanes = half_to_lanes(in_line[HALF_B_LSB +: HALF_W]);
    else
      inj_lanes = half_to_lanes(in_line[HALF_A_LSB +: HALF_W]);
  end

  always_ff @(posedge clk) begin
    if (rst)
      second_q <= 1'b0;
    else if (take && packed_w)
      second_q <= !second_q;
  end
endmodule

// File: rtl/dx_add_stage.sv
module dx_add_stage
  import dx_pkg::*;
#(
  parameter int FIRST = 1,
  parameter int LAST  = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  i_valid,
  input  logic  i_plain,
  input  line_t i_lanes,
  output logic  o_valid,
  output line_t o_lanes
);
  line_t sum;

  // Ripple this stage's share of the running sum; plain lines pass untouched
  always_comb begin
    sum = i_lanes;
    if (!i_plain) begin
      for (int j = FIRST; j <= LAST; j++)
        sum[ELEM_W*j +: ELEM_W] = sum[ELEM_W*(j-1) +: ELEM_W] + sum[ELEM_W*j +: ELEM_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      o_valid <= 1'b0;
    else if (en)
      o_valid <= i_valid;
  end

  always_ff @(posedge clk) begin
    if (en)
      o_lanes <= sum;
  end
endmodule

// File: rtl/delta_line_expander.sv
module delta_line_expander
  import dx_pkg::*;
#(
  parameter int GROUP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [LINE_W-1:0] in_line,
  output logic              in_deq,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LINE_W-1:0] out_line
);
  localparam int STAGES = (N_DELTA + GROUP - 1) / GROUP;

  logic                     adv;
  logic [STAGES:0]          st_valid;
  logic [STAGES:0][LINE_W-1:0] st_lanes;
  logic [STAGES-1:0]        plain_pipe;

  // Single global enable: the output register frees or is empty
  assign adv       = out_ready || !st_valid[STAGES];
  assign out_valid = st_valid[STAGES];
  assign out_line  = st_lanes[STAGES];

  dx_front u_front (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_line   (in_line),
    .adv       (adv),
    .in_deq    (in_deq),
    .inj_valid (st_valid[0]),
    .inj_plain (plain_pipe[0]),
    .inj_lanes (st_lanes[0])
  );

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int FIRST = 1 + s * GROUP;
    localparam int LAST  = (FIRST + GROUP - 1 > N_DELTA) ? N_DELTA : FIRST + GROUP - 1;

    dx_add_stage #(.FIRST(FIRST), .LAST(LAST)) u_add (
      .clk     (clk),
      .rst     (rst),
      .en      (adv),
      .i_valid (st_valid[s]),
      .i_plain (plain_pipe[s]),
      .i_lanes (st_lanes[s]),
      .o_valid (st_valid[s+1]),
      .o_lanes (st_lanes[s+1])
    );

    if (s < STAGES - 1) begin : g_kind
      always_ff @(posedge clk) begin
        if (adv)
          plain_pipe[s+1] <= plain_pipe[s];
      end
    end
  end
endmodule

// File: rtl/dx_checker.sv
module dx_checker
  import dx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [LINE_W-1:0] in_line,
  input logic              in_deq,
  input logic              out_valid,
  input logic              out_ready,
  input logic [LINE_W-1:0] out_line
);
  logic pk;
  assign pk = is_packed(in_line);

  assert_deq_needs_valid_R9: assert property (@(posedge clk) disable iff (rst)
    in_deq |-> in_valid);

  assert_hold_under_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_line)));

  assert_plain_dequeued_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !pk && (out_ready || !out_valid)) |-> in_deq);

  assert_packed_second_half_R4: assert property (@(posedge clk) disable iff (rst)
    (in_deq && pk) |-> ($past(in_valid) && ($past(in_line) == in_line) && !$past(in_deq)));

  assert_no_deq_in_reset_R8: assert property (@(posedge clk)
    rst |-> !in_deq);

  assert_empty_after_reset_R8: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
endmodule

bind delta_line_expander dx_checker u_chk (.*);

// File: tb/delta_line_expander_bench.sv
`timescale 1ns/1ps
module delta_line_expander_bench;
  localparam int GROUP = 4;
  localparam int LAT   = (15 + GROUP - 1) / GROUP;
  localparam int WDOG  = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [511:0] in_line = '0;
  logic in_deq;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [511:0] out_line;

  always #4 clk = ~clk;

  delta_line_expander #(.GROUP(GROUP)) u_delta_line_expander (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_line(in_line), .in_deq(in_deq),
    .out_valid(out_valid), .out_ready(out_ready), .out_line(out_line));

  logic [511:0] in_q[$];
  logic [511:0] exp_q[$];
  int checks = 0, failures = 0;
  int cyc = 0, deq_cnt = 0, out_cnt = 0, ready_pct = 100;
  bit timed_out = 0, prev_stall = 0;
  logic [511:0] prev_line;

  task automatic check(bit ok, string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit looks_packed(logic [511:0] l);
    return l[511:479] == 33'h1;
  endfunction

  function automatic bit fits(logic [511:0] l);
    for (int i = 1; i < 16; i++) begin
      logic [31:0] d = l[32*i +: 32] - l[32*(i-1) +: 32];
      if (d > 32'h1fff) return 0;
    end
    return 1;
  endfunction

  function automatic logic [226:0] to_half(logic [511:0] l);
    logic [226:0] h;
    h[31:0] = l[31:0];
    for (int i = 1; i < 16; i++) begin
      logic [31:0] d = l[32*i +: 32] - l[32*(i-1) +: 32];
      h[32 + 13*(i-1) +: 13] = d[12:0];
    end
    return h;
  endfunction

  function automatic logic [511:0] gen_sorted(logic [31:0] base, int maxd);
    logic [511:0] l;
    logic [31:0] v = base;
    for (int i = 0; i < 16; i++) begin
      if (i > 0) v = v + 32'($urandom_range(0, maxd));
      l[32*i +: 32] = v;
    end
    if (looks_packed(l)) l[511] = 1'b1;
    return l;
  endfunction

  function automatic logic [511:0] gen_random();
    logic [511:0] l;
    for (int i = 0; i < 16; i++) l[32*i +: 32] = $urandom;
    if (looks_packed(l)) l[511] = 1'b1;
    return l;
  endfunction

  // Reference packer: pairs consecutive compressible lines
  task automatic encode(logic [511:0] src[$], output int n_enc);
    int i = 0;
    n_enc = 0;
    while (i < src.size()) begin
      if (i + 1 < src.size() && fits(src[i]) && fits(src[i+1])) begin
        in_q.push_back({32'h0, 1'b1, to_half(src[i]), to_half(src[i+1]), 25'($urandom)});
        exp_q.push_back(src[i]);
        exp_q.push_back(src[i+1]);
        i += 2;
      end else begin
        in_q.push_back(src[i]);
        exp_q.push_back(src[i]);
        i += 1;
      end
      n_enc++;
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    in_valid  = in_q.size() > 0;
    in_line   = (in_q.size() > 0) ? in_q[0] : '0;
    out_ready = ($urandom_range(0, 99) < ready_pct);
    #2;
    cyc++;
    if (cyc > WDOG && !timed_out) begin
      timed_out = 1;
      check(0, "watchdog", 512'(cyc), 512'(WDOG));
    end
    if (in_deq) check(in_valid, "R9 deq without valid", 512'(in_valid), 512'(1));
    if (prev_stall)
      check(out_valid && out_line == prev_line, "R6 hold under stall", out_line, prev_line);
    if (out_valid && out_ready) begin
      out_cnt++;
      if (exp_q.size() == 0)
        check(0, "R5 unexpected extra output", out_line, '0);
      else begin
        check(out_line == exp_q[0], "R3/R5 output line", out_line, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
    if (in_deq && in_q.size() > 0) begin
      void'(in_q.pop_front());
      deq_cnt++;
    end
    prev_stall = out_valid && !out_ready;
    prev_line  = out_line;
  endtask

  task automatic run(logic [511:0] src[$], int pct, string req);
    int n_enc, d0, o0;
    d0 = deq_cnt; o0 = out_cnt;
    ready_pct = pct;
    encode(src, n_enc);
    while ((in_q.size() > 0 || exp_q.size() > 0) && !timed_out) cycle();
    ready_pct = 100;
    for (int k = 0; k < LAT + 2; k++) cycle();
    check(deq_cnt - d0 == n_enc, {req, " dequeue count"}, 512'(deq_cnt - d0), 512'(n_enc));
    check(out_cnt - o0 == src.size(), {req, " output count"}, 512'(out_cnt - o0), 512'(src.size()));
  endtask

  initial begin
    logic [511:0] src[$];
    logic [511:0] l;
    int n;
    // R8: reset holds dequeue low and output empty even with a valid head
    rst = 1'b1;
    in_valid = 1'b1;
    in_line = gen_random();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #2;
      check(!in_deq, "R8 no deq in reset", 512'(in_deq), 512'(0));
      check(!out_valid, "R8 out_valid in reset", 512'(out_valid), 512'(0));
    end
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    #2;
    check(!out_valid, "R8 out_valid after reset", 512'(out_valid), 512'(0));

    // R7/R2: latency of a single plain line
    l = gen_random();
    in_q.push_back(l);
    exp_q.push_back(l);
    n = 0;
    do begin cycle(); n++; end while (!in_deq && n < 20);
    check(in_deq, "R2 plain line dequeued on acceptance", 512'(in_deq), 512'(1));
    for (int m = 1; m < LAT; m++) begin
      cycle();
      check(!out_valid, "R7 too early", 512'(out_valid), 512'(0));
    end
    cycle();
    check(out_valid, "R7 line visible at latency", 512'(out_valid), 512'(1));
    check(out_line == l, "R2 plain unchanged", out_line, l);
    for (int k = 0; k < 3; k++) cycle();

    // R3/R4: sorted compressible lines, full throughput, wrap around 2^32
    src.delete();
    for (int k = 0; k < 40; k++) src.push_back(gen_sorted($urandom, 8191));
    src.push_back(gen_sorted(32'hFFFF_FF00, 8191));
    src.push_back(gen_sorted(32'hFFFF_FFF0, 8191));
    run(src, 100, "R4");
    check(1'b1, "R4 packed pairs expanded", '0, '0);

    // R3: extreme deltas (all 0x1fff, all zero)
    src.delete();
    l[31:0] = 32'hFFFF_0000;
    for (int i = 1; i < 16; i++) l[32*i +: 32] = l[32*(i-1) +: 32] + 32'h1fff;
    src.push_back(l);
    for (int i = 0; i < 16; i++) l[32*i +: 32] = 32'h1234_5678;
    src.push_back(l);
    run(src, 100, "R3");

    // R2: incompressible random lines with backpressure
    src.delete();
    for (int k = 0; k < 30; k++) src.push_back(gen_random());
    run(src, 70, "R2");

    // R1: near-marker plain lines must not be treated as packed
    src.delete();
    for (int k = 0; k < 6; k++) begin
      l = gen_random();
      l[511:479] = (k % 2 == 0) ? 33'h0 : 33'h3;
      l[31:0] = 32'h8000_0000;
      src.push_back(l);
    end
    run(src, 100, "R1");

    // R5/R6: mixed stream under heavy backpressure
    src.delete();
    for (int k = 0; k < 120; k++) begin
      case ($urandom_range(0, 2))
        0: src.push_back(gen_random());
        default: src.push_back(gen_sorted($urandom, ($urandom_range(0, 1) == 0) ? 8191 : 20));
      endcase
    end
    run(src, 45, "R5");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule